// File: doc/BRIEF.md
# Phase-Accumulating Frequency Synthesizer Core with Staged Load Port

This block is the digital heart of a direct digital synthesizer. A 32-bit phase accumulator adds a tuning word to itself on every reference clock, so the output frequency is the tuning word times the reference frequency divided by 2^32. At a 125 MHz reference one tuning step is about 0.029 Hz. A 5-bit phase offset is added at the top of the phase, which gives steps of 11.25 degrees. The core outputs a truncated phase word that a later sine lookup would read. It also outputs a valid flag that drops while the core is powered down, and two status flags taken from the control byte.

Software programs the core through a narrow load port. A write strobe captures data into a staging register. A separate commit strobe then copies the whole 40-bit programming word into the active registers at once, so a retune never shows a half-written word. After reset the port takes whole bytes. One entry sequence with a fixed strap pattern on the low data lines switches it to taking one bit per strobe on data line 7. Both strobes are sampled in the reference clock domain and act on their rising edge. There is no readback path.

Top module: `dds_core`

## Requirements
- R1: A synchronous reset clears the active word, the accumulator, the staging register and the load mode. After reset, phase_o is 0, valid_o is 1, and serial_mode_o, test_bit_err_o and mult_en_o are 0.
- R2: In byte mode, each rising edge of wr_strobe_i captures load_data_i. The first byte is the control byte, whose bits [7:3] are the phase offset, bit 2 is power-down, bit 1 is the test bit and bit 0 is the multiplier enable. The next four bytes are the tuning word, most significant byte first.
- R3: The staged word has no effect on the outputs until a rising edge of commit_i. At the reference clock edge where that rising edge is seen, the word becomes active, and the byte/bit counter restarts from zero.
- R4: While running, the accumulator adds the active tuning word on every clock, modulo 2^32. phase_o equals the top OUT_W accumulator bits plus offset*2^(OUT_W-5), modulo 2^OUT_W.
- R5: Each of the 32 phase-offset codes shifts phase_o by exactly code*2^(OUT_W-5).
- R6: While the active power-down bit is 1, valid_o is 0 and the accumulator holds its value. Committing a word with bit 2 clear resumes counting from the held value.
- R7: An active test bit of 1 sets test_bit_err_o and has no other effect on the phase. mult_en_o mirrors active bit 0.
- R8: A commit that comes after fewer than five bytes transfers the staging register as it stands. In that case the bytes already written this round are replaced and the rest keep their earlier values. Bytes beyond the fifth are ignored.
- R9: The port switches to bit mode only when it sees exactly one write strobe since reset followed by a commit, with load_data_i[2:0] = 3'b011 both at that strobe and at the commit. That commit transfers nothing. Any other first commit leaves the port in byte mode until the next reset.
- R10: In bit mode, each write strobe shifts in load_data_i[7]. Bits arrive tuning-word bit 0 first through bit 31, then control bits 0 to 7. Strobes beyond the fortieth are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_strobe_i | input | 1 | Load write strobe, acts on rising edge |
| commit_i | input | 1 | Commit strobe, acts on rising edge |
| load_data_i | input | 8 | Load data; bit 7 is the serial line, bits 2:0 the strap |
| phase_o | output | OUT_W | Truncated phase including offset |
| valid_o | output | 1 | Low while powered down |
| test_bit_err_o | output | 1 | Active test bit is set |
| mult_en_o | output | 1 | Active multiplier-enable bit |
| serial_mode_o | output | 1 | Port is in bit mode |

## Verification
The accumulator is driven with small, mid-range, half-scale and all-ones tuning words. These tell plain addition apart from carry and wrap faults at 2^32. The offset is swept through all 32 codes with a zero tuning word, so a shifted or dropped offset bit shows alone. In byte mode, words are written and left uncommitted, cut short, or given a sixth byte, which separates the staging rules from the commit rule. Bit mode is entered with and without the strap and at a late attempt, then loaded with a bit-reversed pattern so that any error in bit order or in control/tuning placement shows up.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int CTRL_W   = 8;
    localparam int TW_W     = 32;
    localparam int WORD_W   = CTRL_W + TW_W;
    localparam int NBYTES   = WORD_W / 8;
    localparam int OFF_W    = 5;
    localparam int CNT_W    = $clog2(WORD_W + 1);
    localparam logic [2:0] STRAP_SER = 3'b011;

    typedef struct packed {
        logic [OFF_W-1:0] phase_off;
        logic             pwr_down;
        logic             test_bit;
        logic             mult_en;
    } ctrl_t;

    typedef struct packed {
        ctrl_t           ctrl;
        logic [TW_W-1:0] tune;
    } prog_word_t;

    typedef enum logic {
        MODE_BYTE = 1'b0,
        MODE_BIT  = 1'b1
    } load_mode_e;

    // Byte 0 lands in the control field, bytes 1..4 fill the tuning word from the top.
    function automatic prog_word_t put_byte(prog_word_t w, logic [CNT_W-1:0] idx,
                                            logic [7:0] b);
        logic [WORD_W-1:0] v;
        v = w;
        v[WORD_W-1-8*int'(idx) -: 8] = b;
        return prog_word_t'(v);
    endfunction

    function automatic logic strap_match(logic [2:0] d);
        return d == STRAP_SER;
    endfunction

endpackage

// File: rtl/dds_rise_det.sv
module dds_rise_det (
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/dds_load_port.sv
module dds_load_port
    import dds_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       wr_rise_i,
    input  logic       commit_rise_i,
    input  logic [7:0] data_i,
    output prog_word_t stage_o,
    output logic       xfer_o,
    output load_mode_e mode_o
);
    prog_word_t       stage_q;
    load_mode_e       mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             entry_open_q;
    logic             strap_q;
    logic             entry_hit;
    logic [CNT_W-1:0] cnt_lim;

    assign cnt_lim   = (mode_q == MODE_BYTE) ? CNT_W'(NBYTES) : CNT_W'(WORD_W);
    assign entry_hit = commit_rise_i && entry_open_q && (mode_q == MODE_BYTE)
                     && (cnt_q == CNT_W'(1)) && strap_q && strap_match(data_i[2:0]);
    assign xfer_o    = commit_rise_i && !entry_hit;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q      <= '0;
            mode_q       <= MODE_BYTE;
            cnt_q        <= '0;
            entry_open_q <= 1'b1;
            strap_q      <= 1'b0;
        end else if (commit_rise_i) begin
            cnt_q        <= '0;
            entry_open_q <= 1'b0;
            if (entry_hit) mode_q <= MODE_BIT;
        end else if (wr_rise_i && (cnt_q < cnt_lim)) begin
            cnt_q <= cnt_q + 1'b1;
            if (mode_q == MODE_BYTE) begin
                stage_q <= put_byte(stage_q, cnt_q, data_i);
                if (cnt_q == '0) strap_q <= strap_match(data_i[2:0]);
            end else begin
                stage_q <= prog_word_t'({data_i[7], stage_q[WORD_W-1:1]});
            end
        end
    end

    assign stage_o = stage_q;
    assign mode_o  = mode_q;
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
    import dds_pkg::*;
#(
    parameter int OUT_W = 14
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [TW_W-1:0]  tune_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             hold_i,
    output logic [TW_W-1:0]  acc_o,
    output logic [OUT_W-1:0] phase_o
);
    localparam int PAD_W = OUT_W - OFF_W;

    logic [TW_W-1:0] acc_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)        acc_q <= '0;
        else if (!hold_i) acc_q <= acc_q + tune_i;
    end

    assign acc_o   = acc_q;
    assign phase_o = acc_q[TW_W-1 -: OUT_W] + {off_i, {PAD_W{1'b0}}};
endmodule

// File: rtl/dds_core.sv
module dds_core
    import dds_pkg::*;
#(
    parameter int OUT_W = 14
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_strobe_i,
    input  logic             commit_i,
    input  logic [7:0]       load_data_i,
    output logic [OUT_W-1:0] phase_o,
    output logic             valid_o,
    output logic             test_bit_err_o,
    output logic             mult_en_o,
    output logic             serial_mode_o
);
    logic       wr_rise, commit_rise, xfer;
    prog_word_t stage, act_q;
    load_mode_e mode;
    logic [TW_W-1:0] acc_q;
    logic [TW_W-1:0] tune_act;

    dds_rise_det u_wr_det (
        .clk_i(clk_i), .rst_i(rst_i), .lvl_i(wr_strobe_i), .rise_o(wr_rise)
    );
    dds_rise_det u_commit_det (
        .clk_i(clk_i), .rst_i(rst_i), .lvl_i(commit_i), .rise_o(commit_rise)
    );

    dds_load_port u_port (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .wr_rise_i    (wr_rise),
        .commit_rise_i(commit_rise),
        .data_i       (load_data_i),
        .stage_o      (stage),
        .xfer_o       (xfer),
        .mode_o       (mode)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i)     act_q <= '0;
        else if (xfer) act_q <= stage;
    end

    assign tune_act = act_q.tune;

    dds_phase_acc #(.OUT_W(OUT_W)) u_acc (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tune_i (tune_act),
        .off_i  (act_q.ctrl.phase_off),
        .hold_i (act_q.ctrl.pwr_down),
        .acc_o  (acc_q),
        .phase_o(phase_o)
    );

    assign valid_o        = !act_q.ctrl.pwr_down;
    assign test_bit_err_o = act_q.ctrl.test_bit;
    assign mult_en_o      = act_q.ctrl.mult_en;
    assign serial_mode_o  = (mode == MODE_BIT);
endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk (
    input logic        clk_i,
    input logic        rst_i,
    input logic        valid_o,
    input logic        serial_mode_o,
    input logic [7:0]  load_data_i,
    input logic [31:0] acc_q,
    input logic [31:0] tune_act,
    input logic        commit_rise
);
    // R6: accumulator frozen while powered down
    p_pd_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |=> acc_q == $past(acc_q));

    // R4: accumulator steps by the active tuning word
    p_acc_step_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> acc_q == $past(acc_q + tune_act));

    // R3: active tuning word changes only after a commit edge
    p_tune_on_commit_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (tune_act != $past(tune_act)) |-> $past(commit_rise));

    // R9: bit mode entered only at a commit with the strap present
    p_ser_entry_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(serial_mode_o) |-> $past(commit_rise && load_data_i[2:0] == 3'b011));

    // R9: bit mode leaves only through reset
    p_ser_sticky_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(serial_mode_o) |-> $past(rst_i));
endmodule

bind dds_core dds_core_chk u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .valid_o      (valid_o),
    .serial_mode_o(serial_mode_o),
    .load_data_i  (load_data_i),
    .acc_q        (acc_q),
    .tune_act     (tune_act),
    .commit_rise  (commit_rise)
);

// File: tb/dds_core_tb_top.sv
`timescale 1ns/1ps
module dds_core_tb_top;
    localparam int OUT_W = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr = 1'b0, cm = 1'b0;
    logic [7:0] dat = 8'h00;
    logic [OUT_W-1:0] phase;
    logic valid, terr, mult, ser;

    int checks = 0, fails = 0;
    bit finished = 0;

    // Bench-side requirement model
    logic [39:0] m_stage = '0;
    logic [39:0] m_act   = '0;
    logic [31:0] m_acc   = '0;
    int          m_cnt   = 0;
    bit          m_ser   = 0;
    bit          m_xfer  = 1;
    logic        cm_prev = 1'b0;

    always #2 clk = ~clk;

    dds_core #(.OUT_W(OUT_W)) dut_i (
        .clk_i(clk), .rst_i(rst), .wr_strobe_i(wr), .commit_i(cm),
        .load_data_i(dat), .phase_o(phase), .valid_o(valid),
        .test_bit_err_o(terr), .mult_en_o(mult), .serial_mode_o(ser)
    );

    always @(posedge clk) begin
        cm_prev <= cm;
        if (rst) begin
            m_act <= '0;
            m_acc <= '0;
            cm_prev <= 1'b0;
        end else begin
            if (!m_act[34]) m_acc <= m_acc + m_act[31:0];
            if (cm && !cm_prev && m_xfer) m_act <= m_stage;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [OUT_W-1:0] exp_phase();
        return m_acc[31 -: OUT_W] + OUT_W'({m_act[39:35], {(OUT_W-5){1'b0}}});
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; wr = 0; cm = 0; dat = 0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        m_stage = '0; m_cnt = 0; m_ser = 0; m_xfer = 1;
    endtask

    task automatic wr_byte(logic [7:0] b);
        @(negedge clk); dat = b; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        if (!m_ser) begin
            if (m_cnt < 5) begin m_stage[39-8*m_cnt -: 8] = b; m_cnt++; end
        end else if (m_cnt < 40) begin
            m_stage = {b[7], m_stage[39:1]}; m_cnt++;
        end
    endtask

    task automatic commit();
        @(negedge clk); cm = 1'b1;
        @(negedge clk); cm = 1'b0;
        m_cnt = 0;
    endtask

    task automatic load_par(logic [7:0] c, logic [31:0] t);
        wr_byte(c);
        for (int i = 3; i >= 0; i--) wr_byte(t[8*i +: 8]);
        commit();
    endtask

    task automatic load_ser(logic [7:0] c, logic [31:0] t, int extra);
        logic [39:0] w;
        w = {c, t};
        for (int i = 0; i < 40; i++) wr_byte({w[i], 7'h00});
        for (int i = 0; i < extra; i++) wr_byte({~w[i], 7'h00});
        commit();
    endtask

    task automatic try_entry(bit strap, bit expect_enter);
        m_xfer = !expect_enter;
        wr_byte(strap ? 8'h03 : 8'h00);
        commit();
        m_xfer = 1;
        if (expect_enter) m_ser = 1;
    endtask

    task automatic run(int n, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, 64'(phase), 64'(exp_phase()));
        end
        chk(req, {61'd0, valid, terr, mult}, {61'd0, !m_act[34], m_act[33], m_act[32]});
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [OUT_W-1:0] held;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1", {59'd0, phase}, 64'd0);
        chk("R1", {60'd0, valid, terr, mult, ser}, {60'd0, 4'b1000});

        // R2 R4 byte load and accumulation
        load_par(8'h00, 32'h0123_4567);
        run(20, "R2");
        foreach (m_stage[i]) ; // no-op keeps model visible
        load_par(8'h00, 32'hFFFF_FFFF); run(8, "R4");
        load_par(8'h00, 32'h8000_0000); run(8, "R4");
        load_par(8'h00, 32'h0000_0001); run(8, "R4");
        load_par(8'h00, 32'h3C5A_9E07); run(8, "R4");

        // R3 staged word stays inactive until commit
        wr_byte(8'h00); wr_byte(8'h7F); wr_byte(8'h00); wr_byte(8'h00); wr_byte(8'h00);
        run(10, "R3");
        commit(); run(6, "R3");

        // R5 offset sweep with zero tuning word
        for (int k = 0; k < 32; k++) begin
            load_par(8'(k << 3), 32'h0);
            run(2, "R5");
        end

        // R6 power down holds and resumes
        load_par(8'h04, 32'h1111_1111);
        @(negedge clk); held = phase;
        run(6, "R6");
        chk("R6", 64'(phase), 64'(held));
        chk("R6", {63'd0, valid}, 64'd0);
        load_par(8'h00, 32'h1111_1111);
        run(6, "R6");

        // R7 test bit and multiplier flag
        load_par(8'h02, 32'h0040_0000); run(6, "R7");
        chk("R7", {63'd0, terr}, 64'd1);
        load_par(8'h01, 32'h0040_0000); run(4, "R7");
        chk("R7", {63'd0, mult}, 64'd1);

        // R8 short word and surplus bytes
        wr_byte(8'h18); wr_byte(8'h22); commit(); run(6, "R8");
        load_par(8'h00, 32'h0102_0304);
        wr_byte(8'h08); wr_byte(8'h05); wr_byte(8'h06); wr_byte(8'h07); wr_byte(8'h09);
        wr_byte(8'hFF); commit(); run(6, "R8");

        // R9 entry without strap stays in byte mode
        do_reset();
        try_entry(1'b0, 1'b0);
        @(negedge clk); chk("R9", {63'd0, ser}, 64'd0);
        load_par(8'h00, 32'h0200_0000); run(6, "R9");

        // R9 late attempt is refused
        do_reset();
        load_par(8'h00, 32'h0300_0000);
        try_entry(1'b1, 1'b0);
        @(negedge clk); chk("R9", {63'd0, ser}, 64'd0);
        run(4, "R9");

        // R9 proper entry, R10 bit-mode loads
        do_reset();
        try_entry(1'b1, 1'b1);
        @(negedge clk); chk("R9", {63'd0, ser}, 64'd1);
        run(3, "R9");
        load_ser(8'h28, 32'h0A0B_0C0D, 0); run(10, "R10");
        load_ser(8'h00, 32'hF000_0001, 3); run(10, "R10");

        // R1 reset leaves bit mode
        do_reset();
        @(negedge clk);
        chk("R1", {60'd0, valid, terr, mult, ser}, {60'd0, 4'b1000});
        chk("R1", {59'd0, phase}, 64'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule